// File: doc/BRIEF.md
# Paged Segmentation Address Walker

The walker turns a two-part logical address, an 18-bit segment number and a 16-bit offset, into a physical address. It reads translation tables through one sequential memory read port, one read at a time. A segment entry gives the segment's length and the base of that segment's page table. The offset is checked against the length and then split. The upper 6 bits index the page table and the lower 10 bits are the word within a 1K-word page. The frame read from the page table is placed above the word offset to form the physical address.

The segment table can be laid out in one of two ways. In flat mode it is one contiguous table that starts at the table base input, so a walk takes two reads. In paged mode the segment number is split into an 8-bit field and a 10-bit field. The first field indexes a table of segment-table pages and the second selects the entry within that page, so a walk takes three reads. A lookup that meets an invalid entry stops at once and reports the level where it stopped. An offset past the segment's end stops the walk with a bound fault.

Top module: `pseg_walker`

## Requirements
- R1: After reset, busy, mem_rd and done are low, and fault and paddr are zero.
- R2: In flat mode (req_paged=0) the first read is at stbr + segment number, and a walk with no fault makes exactly two reads.
- R3: In paged mode (req_paged=1) the first read is at stbr + seg[17:10]. Its base field plus seg[9:0] gives the address of the segment entry. A walk with no fault makes exactly three reads.
- R4: The page-table read is at the segment entry's base field + offset[15:10].
- R5: On success, paddr = {frame, offset[9:0]} and fault = 0.
- R6: If offset >= length, the walk ends with fault = 4'b1000 and no page-table read. An offset of length-1 is still translated.
- R7: Every entry has its valid flag in bit 39. An invalid entry ends the walk with no further read. The fault is 4'b0001 for a segment-table page, 4'b0010 for a segment entry and 4'b0100 for a page entry. The entry fields are: length in bits 38:22, base in bits 21:0, frame in bits 13:0.
- R8: A segment entry that is invalid reports 4'b0010 even when its length field would also cause a bound fault.
- R9: req_valid is ignored while busy is high.
- R10: mem_rd is a one-cycle pulse. No new read is issued before mem_rvalid answers the previous one.
- R11: done is high for exactly one cycle with busy low. Outside that cycle, fault and paddr are zero. A fault result carries paddr = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Start a walk (taken when not busy) |
| req_paged | input | 1 | 1 selects the paged segment table |
| req_seg | input | 18 | Segment number |
| req_off | input | 16 | Offset within the segment |
| stbr | input | 22 | Base address of the first-level table |
| busy | output | 1 | Walk in progress |
| mem_rd | output | 1 | Table read request pulse |
| mem_addr | output | 22 | Table read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 40 | Read data (table entry) |
| done | output | 1 | Result valid for one cycle |
| paddr | output | 24 | Translated physical address |
| fault | output | 4 | One-hot fault code |

## Verification
Two checks act on the same segment-entry response: the valid-flag test and the length bound test. They can both fire in one cycle. The bench provokes this with an invalid segment entry whose length field is smaller than the offset. The reference model expects the invalid-entry code and no page read. A behavioural model predicts every read address and the final result, and the bench compares them on every clock. It also sends requests while the walker is busy and expects them to leave the read stream unchanged.

// File: rtl/pseg_pkg.sv
package pseg_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SPT,
      ST_SEG,
      ST_PG,
      ST_DONE
   } walk_st_t;

   localparam int FB_SPT = 0;
   localparam int FB_SEG = 1;
   localparam int FB_PG  = 2;
   localparam int FB_BND = 3;
   localparam int FLT_W  = 4;
endpackage

// File: rtl/pseg_entry_dec.sv
module pseg_entry_dec #(
   parameter int DATA_W  = 40,
   parameter int LEN_W   = 17,
   parameter int AW      = 22,
   parameter int FRAME_W = 14
) (
   input  logic [DATA_W-1:0]  ent,
   output logic               vld,
   output logic [LEN_W-1:0]   len,
   output logic [AW-1:0]      base,
   output logic [FRAME_W-1:0] frame
);
   localparam int LEN_LSB = DATA_W - 1 - LEN_W;

   assign vld   = ent[DATA_W-1];
   assign len   = ent[LEN_LSB +: LEN_W];
   assign base  = ent[AW-1:0];
   assign frame = ent[FRAME_W-1:0];
endmodule

// File: rtl/pseg_addr_gen.sv
module pseg_addr_gen
   import pseg_pkg::*;
#(
   parameter int SEG_W    = 18,
   parameter int SEG_LO_W = 10,
   parameter int PAGE_W   = 6,
   parameter int AW       = 22,
   parameter bit PAGED_EN = 1'b1
) (
   input  walk_st_t          st,
   input  logic              paged,
   input  logic [AW-1:0]     stbr,
   input  logic [AW-1:0]     spt_base,
   input  logic [AW-1:0]     pt_base,
   input  logic [SEG_W-1:0]  seg,
   input  logic [PAGE_W-1:0] page,
   output logic [AW-1:0]     addr
);
   logic [AW-1:0] spt_addr;
   logic [AW-1:0] seg_addr;

   generate
      if (PAGED_EN) begin : g_paged
         logic [AW-1:0] hi_ext;
         logic [AW-1:0] lo_ext;
         assign hi_ext   = AW'(seg[SEG_W-1:SEG_LO_W]);
         assign lo_ext   = AW'(seg[SEG_LO_W-1:0]);
         assign spt_addr = stbr + hi_ext;
         assign seg_addr = paged ? (spt_base + lo_ext) : (stbr + AW'(seg));
      end else begin : g_flat
         logic unused_in;
         assign unused_in = paged ^ (^spt_base);
         assign spt_addr  = stbr;
         assign seg_addr  = stbr + AW'(seg);
      end
   endgenerate

   always_comb begin
      case (st)
         ST_SPT:  addr = spt_addr;
         ST_SEG:  addr = seg_addr;
         ST_PG:   addr = pt_base + AW'(page);
         default: addr = '0;
      endcase
   end
endmodule

// File: rtl/pseg_walker.sv
module pseg_walker
   import pseg_pkg::*;
#(
   parameter int  SEG_W    = 18,
   parameter int  SEG_LO_W = 10,
   parameter int  OFF_W    = 16,
   parameter int  WORD_W   = 10,
   parameter int  AW       = 22,
   parameter int  DATA_W   = 40,
   parameter int  FRAME_W  = 14,
   parameter bit  PAGED_EN = 1'b1,
   localparam int PAGE_W   = OFF_W - WORD_W,
   localparam int LEN_W    = OFF_W + 1,
   localparam int PA_W     = FRAME_W + WORD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_paged,
   input  logic [SEG_W-1:0]  req_seg,
   input  logic [OFF_W-1:0]  req_off,
   input  logic [AW-1:0]     stbr,
   output logic              busy,
   output logic              mem_rd,
   output logic [AW-1:0]     mem_addr,
   input  logic              mem_rvalid,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              done,
   output logic [PA_W-1:0]   paddr,
   output logic [FLT_W-1:0]  fault
);
   generate
      if (DATA_W < 1 + LEN_W + AW) begin : g_bad_data
         $error("entry word too narrow for valid, length and base fields");
      end
      if (FRAME_W > AW) begin : g_bad_frame
         $error("frame field must fit inside the base field");
      end
      if (SEG_LO_W >= SEG_W || PAGE_W < 1) begin : g_bad_split
         $error("field split leaves an empty field");
      end
   endgenerate

   walk_st_t             st_q;
   logic                 issue_q;
   logic                 paged_q;
   logic [SEG_W-1:0]     seg_q;
   logic [OFF_W-1:0]     off_q;
   logic [AW-1:0]        stbr_q;
   logic [AW-1:0]        spt_base_q;
   logic [AW-1:0]        pt_base_q;
   logic [FLT_W-1:0]     res_flt_q;
   logic [PA_W-1:0]      res_pa_q;

   logic                 e_vld;
   logic [LEN_W-1:0]     e_len;
   logic [AW-1:0]        e_base;
   logic [FRAME_W-1:0]   e_frame;
   logic [AW-1:0]        nxt_addr;
   logic                 over_len;

   pseg_entry_dec #(
      .DATA_W (DATA_W),
      .LEN_W  (LEN_W),
      .AW     (AW),
      .FRAME_W(FRAME_W)
   ) i_dec (
      .ent  (mem_rdata),
      .vld  (e_vld),
      .len  (e_len),
      .base (e_base),
      .frame(e_frame)
   );

   pseg_addr_gen #(
      .SEG_W   (SEG_W),
      .SEG_LO_W(SEG_LO_W),
      .PAGE_W  (PAGE_W),
      .AW      (AW),
      .PAGED_EN(PAGED_EN)
   ) i_agen (
      .st      (st_q),
      .paged   (paged_q),
      .stbr    (stbr_q),
      .spt_base(spt_base_q),
      .pt_base (pt_base_q),
      .seg     (seg_q),
      .page    (off_q[OFF_W-1:WORD_W]),
      .addr    (nxt_addr)
   );

   assign over_len = {1'b0, off_q} >= e_len;
   assign busy     = (st_q != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         issue_q    <= 1'b0;
         paged_q    <= 1'b0;
         seg_q      <= '0;
         off_q      <= '0;
         stbr_q     <= '0;
         spt_base_q <= '0;
         pt_base_q  <= '0;
         res_flt_q  <= '0;
         res_pa_q   <= '0;
         mem_rd     <= 1'b0;
         mem_addr   <= '0;
         done       <= 1'b0;
         paddr      <= '0;
         fault      <= '0;
      end else begin
         mem_rd <= 1'b0;
         done   <= 1'b0;
         paddr  <= '0;
         fault  <= '0;
         if (issue_q) begin
            mem_rd   <= 1'b1;
            mem_addr <= nxt_addr;
            issue_q  <= 1'b0;
         end
         case (st_q)
            ST_IDLE: begin
               if (req_valid) begin
                  paged_q   <= req_paged;
                  seg_q     <= req_seg;
                  off_q     <= req_off;
                  stbr_q    <= stbr;
                  res_flt_q <= '0;
                  res_pa_q  <= '0;
                  issue_q   <= 1'b1;
                  st_q      <= (PAGED_EN && req_paged) ? ST_SPT : ST_SEG;
               end
            end
            ST_SPT: begin
               if (mem_rvalid && !issue_q) begin
                  if (!e_vld) begin
                     res_flt_q[FB_SPT] <= 1'b1;
                     st_q              <= ST_DONE;
                  end else begin
                     spt_base_q <= e_base;
                     issue_q    <= 1'b1;
                     st_q       <= ST_SEG;
                  end
               end
            end
            ST_SEG: begin
               if (mem_rvalid && !issue_q) begin
                  if (!e_vld) begin
                     res_flt_q[FB_SEG] <= 1'b1;
                     st_q              <= ST_DONE;
                  end else if (over_len) begin
                     res_flt_q[FB_BND] <= 1'b1;
                     st_q              <= ST_DONE;
                  end else begin
                     pt_base_q <= e_base;
                     issue_q   <= 1'b1;
                     st_q      <= ST_PG;
                  end
               end
            end
            ST_PG: begin
               if (mem_rvalid && !issue_q) begin
                  if (!e_vld) res_flt_q[FB_PG] <= 1'b1;
                  else        res_pa_q <= {e_frame, off_q[WORD_W-1:0]};
                  st_q <= ST_DONE;
               end
            end
            ST_DONE: begin
               done  <= 1'b1;
               fault <= res_flt_q;
               paddr <= res_pa_q;
               st_q  <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   // R10
   rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |=> !mem_rd);

   // R1
   idle_no_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_rd);

   // R11
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy ##1 !done);

   // R11
   quiet_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> (fault == '0 && paddr == '0));

   // R7
   fault_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(fault));

   // R11
   fault_zero_pa_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && fault != '0) |-> paddr == '0);
endmodule

// File: tb/test_pseg_walker.sv
`timescale 1ns/1ps
module test_pseg_walker;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_paged = 1'b0;
   logic [17:0] req_seg = '0;
   logic [15:0] req_off = '0;
   logic [21:0] stbr = '0;
   logic        busy;
   logic        mem_rd;
   logic [21:0] mem_addr;
   logic        mem_rvalid = 1'b0;
   logic [39:0] mem_rdata = '0;
   logic        done;
   logic [23:0] paddr;
   logic [3:0]  fault;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int lat = 1;
   int cnt = 0;
   int pend = 0;
   bit outst = 0;
   bit prev_rd = 0;
   bit prev_done = 0;
   bit got_done = 0;
   int exp_q[$];
   int exp_fault = 0;
   int exp_pa = 0;
   logic [39:0] mem [int];

   always #2.5 clk = ~clk;

   pseg_walker i_pseg_walker (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_paged(req_paged),
      .req_seg(req_seg), .req_off(req_off), .stbr(stbr), .busy(busy),
      .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
      .mem_rdata(mem_rdata), .done(done), .paddr(paddr), .fault(fault)
   );

   function automatic logic [39:0] rd(int a);
      return mem.exists(a) ? mem[a] : 40'd0;
   endfunction

   function automatic logic [39:0] seg_ent(bit v, int len, int base);
      return {v, 17'(len), 22'(base)};
   endfunction

   function automatic logic [39:0] ptr_ent(bit v, int base);
      return {v, 17'd0, 22'(base)};
   endfunction

   task automatic check(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic model(bit pg, int seg, int off, int base);
      logic [39:0] e;
      int a;
      exp_q.delete();
      exp_fault = 0;
      exp_pa = 0;
      if (pg) begin
         a = base + (seg >> 10);
         exp_q.push_back(a);
         e = rd(a);
         if (!e[39]) begin exp_fault = 1; return; end
         a = int'(e[21:0]) + (seg % 1024);
      end else begin
         a = base + seg;
      end
      exp_q.push_back(a);
      e = rd(a);
      if (!e[39]) begin exp_fault = 2; return; end
      if (off >= int'(e[38:22])) begin exp_fault = 8; return; end
      a = int'(e[21:0]) + (off >> 10);
      exp_q.push_back(a);
      e = rd(a);
      if (!e[39]) begin exp_fault = 4; return; end
      exp_pa = int'(e[13:0]) * 1024 + (off % 1024);
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         cyc++;
         mem_rvalid = 1'b0;
         if (cnt > 0) begin
            cnt--;
            if (cnt == 0) begin
               mem_rvalid = 1'b1;
               mem_rdata  = rd(pend);
               outst      = 0;
            end
         end
         if (mem_rd && prev_rd) check(0, "R10 read pulse", 1, 0);
         if (mem_rd) begin
            check(!outst, "R10 read while outstanding", 1, 0);
            if (exp_q.size() == 0) begin
               check(0, "R6/R7 unexpected read", int'(mem_addr), 0);
            end else begin
               int ea;
               ea = exp_q.pop_front();
               check(int'(mem_addr) == ea, "R2/R3/R4 read address", int'(mem_addr), ea);
            end
            outst = 1;
            pend  = int'(mem_addr);
            cnt   = lat;
         end
         if (done) begin
            check(!busy, "R11 busy at done", busy, 0);
            check(exp_q.size() == 0, "R2/R3 read count", exp_q.size(), 0);
            check(int'(fault) == exp_fault, "R5/R6/R7/R8 fault", fault, exp_fault);
            check(int'(paddr) == exp_pa, "R5 paddr", paddr, exp_pa);
            got_done = 1;
         end else begin
            check(fault == 4'd0 && paddr == 24'd0, "R11 idle result", paddr, 0);
         end
         if (done && prev_done) check(0, "R11 done width", 1, 0);
         prev_rd   = mem_rd;
         prev_done = done;
      end
   end

   task automatic walk(bit pg, int seg, int off, int base, int l, bit poke);
      lat = l;
      model(pg, seg, off, base);
      got_done = 0;
      @(negedge clk);
      req_valid = 1'b1;
      req_paged = pg;
      req_seg   = 18'(seg);
      req_off   = 16'(off);
      stbr      = 22'(base);
      @(negedge clk);
      req_valid = 1'b0;
      if (poke) begin
         // R9: requests while busy must not change the read stream
         for (int k = 0; k < 3; k++) begin
            req_valid = 1'b1;
            req_paged = ~pg;
            req_seg   = 18'(seg + 9);
            req_off   = 16'(off ^ 16'hFFFF);
            stbr      = 22'(base + 77);
            @(negedge clk);
         end
         req_valid = 1'b0;
      end
      while (!got_done) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      mem[32'h105] = seg_ent(1, 32'h2000, 32'h4000);
      mem[32'h4003] = {1'b1, 39'h1234};
      mem[32'h4007] = {1'b1, 39'h0ABC};
      mem[32'h106] = seg_ent(0, 32'h10, 32'h5000);
      mem[32'h203] = ptr_ent(1, 32'h8000);
      mem[32'h8007] = seg_ent(1, 32'h10000, 32'h9000);
      mem[32'h9000 + 63] = {1'b1, 39'h3FFF};
      mem[32'h200 + 255] = ptr_ent(1, 32'h10000);
      mem[32'h10000 + 1023] = seg_ent(1, 32'h400, 32'hA000);
      mem[32'hA000] = {1'b1, 39'h5};

      repeat (3) @(negedge clk);
      // R1: reset state
      check(!busy && !mem_rd && !done, "R1 reset controls", {busy, mem_rd, done}, 0);
      check(fault == 0 && paddr == 0, "R1 reset result", paddr, 0);
      rst_n = 1'b1;
      @(negedge clk);

      walk(0, 5, 16'h0C0D, 32'h100, 1, 0);   // R2 R4 R5 flat success
      walk(0, 5, 16'h1FFF, 32'h100, 2, 0);   // R6 last legal offset
      walk(0, 5, 16'h2000, 32'h100, 3, 0);   // R6 offset equal to length traps
      walk(0, 6, 16'h8000, 32'h100, 1, 0);   // R8 invalid wins over bound
      walk(0, 5, 16'h1400, 32'h100, 2, 0);   // R7 page entry invalid
      walk(1, 32'hC07, 16'hFC05, 32'h200, 1, 0);  // R3 paged success
      walk(1, 32'h1001, 16'h0001, 32'h200, 2, 0); // R7 segment-table page invalid
      walk(1, 32'h3FFFF, 16'h03FF, 32'h200, 4, 0); // R3 top segment number
      walk(0, 5, 16'h0C0D, 32'h100, 4, 1);   // R9 requests during walk ignored
      walk(0, 9, 16'h0000, 32'h100, 1, 0);   // R7 absent segment entry

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(5 * 100000);
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule